// File: doc/BRIEF.md
# Sector Map and Boot Lockout

This block sits in the control path of a 128K x 8 flash-style array, in front of the program and erase sequencer. It turns a 17-bit byte address into the index of one of five erase sectors, holds a sticky boot protection flag, and decides for each requested operation (byte program, sector erase or chip erase) whether it may go ahead and which sectors an erase may clear. A parameter selects the bottom-boot layout (boot sector at the low end) or the mirrored top-boot layout.

The sequencer pulses `op_start` with the operation kind, the target address and the current level of the high-voltage override. One cycle later the block presents the registered verdict: the kind, the sector, a write-permit bit and a five-bit erase mask. The protection flag is set by a strobe and survives the ordinary reset; only the power-on clear port removes it. A second parameter removes the override path, which turns a set flag into a permanent one. In identification mode, a read at the boot sector base plus two reports the flag. The block has no streaming data path; every pin is a plain control or status level.

Top module: `secmap_lockout`

## Requirements
- R1: With TOP_BOOT=0, `sector_idx` follows `addr` combinationally: 0 (boot) for 0x00000-0x03FFF, 1 for 0x04000-0x05FFF, 2 for 0x06000-0x07FFF, 3 for 0x08000-0x0FFFF, 4 for 0x10000-0x1FFFF.
- R2: With TOP_BOOT=1, `sector_idx` is 0 for 0x1C000-0x1FFFF, 1 for 0x1A000-0x1BFFF, 2 for 0x18000-0x19FFF, 3 for 0x10000-0x17FFF, 4 for 0x00000-0x0FFFF.
- R3: A `lock_set` pulse makes `lock_flag` 1 from the next cycle on; it stays 1 through any `rst_n` assertion and returns to 0 only while `por_n` is low.
- R4: A program (`op_kind`=1) or sector erase (`op_kind`=2) whose address lies in the boot sector gets `dec_permit`=0 when the flag is set and no override applies; the same operations on sectors 1-4 always get `dec_permit`=1.
- R5: A chip erase (`op_kind`=3) always gets `dec_permit`=1; its mask is 5'b11110 (bit 0 = boot sector cleared) when the flag is set and no override applies, else 5'b11111.
- R6: With OVR_EN=1, `hv_override`=1 in the start cycle removes the effect of the flag for that operation (boot program and erase permitted, chip erase mask 5'b11111); with the override low the flag protects again.
- R7: With OVR_EN=0, `hv_override` has no effect on any result.
- R8: Erase mask bit i stands for sector i. A permitted sector erase yields a mask with only the target sector's bit set; a refused one yields 0; program and idle (`op_kind`=0) yield mask 0, and idle yields `dec_permit`=0.
- R9: `dec_valid` is 1 exactly in the cycle after a cycle with `op_start`=1, and the verdict uses the address, kind, override and flag of that start cycle.
- R10: `id_hit` is 1 when `id_mode`=1 and `addr` equals the boot sector base plus 2 (0x00002 bottom-boot, 0x1C002 top-boot); `id_bit` then equals the flag and is 0 whenever `id_hit` is 0.
- R11: While `rst_n` is low, `dec_valid`, `dec_kind`, `dec_sector`, `dec_permit` and `dec_erase_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the verdict registers |
| por_n | input | 1 | Asynchronous active-low power-on clear of the protection flag |
| addr | input | 17 | Byte address of the operation or identification read |
| op_start | input | 1 | One-cycle start strobe for an operation |
| op_kind | input | 2 | 0 idle, 1 program, 2 sector erase, 3 chip erase |
| lock_set | input | 1 | Strobe that sets the protection flag |
| hv_override | input | 1 | High-voltage override level, sampled at start |
| id_mode | input | 1 | Identification read mode |
| sector_idx | output | 3 | Combinational sector of `addr` |
| lock_flag | output | 1 | Current protection flag |
| id_hit | output | 1 | Identification read addresses the flag location |
| id_bit | output | 1 | Flag as read in identification mode |
| dec_valid | output | 1 | Verdict valid, one cycle after start |
| dec_kind | output | 2 | Registered operation kind |
| dec_sector | output | 3 | Registered target sector |
| dec_permit | output | 1 | Operation allowed |
| dec_erase_mask | output | 5 | Sectors the erase may clear, bit i = sector i |

## Verification
The hardest state to reach is a protected boot sector under every combination of operation kind and override level, in both layouts, with the flag carried across an ordinary reset. The bench sets the flag with one strobe, then repeats a full sweep of kinds, overrides and one probe address per 8K region against a bottom-boot instance with the override path and a top-boot instance without it, so the same stimulus shows the bypass working on one and ignored on the other. It pulses `rst_n` after locking, checks the flag again, and clears it only through `por_n`.

// File: rtl/secmap_pkg.sv
package secmap_pkg;

  localparam int NUM_SECT = 5;
  localparam int SECT_W   = 3;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SERASE = 2'd2,
    OP_CERASE = 2'd3
  } op_kind_e;

  typedef enum logic [SECT_W-1:0] {
    SEC_BOOT  = 3'd0,
    SEC_PAR1  = 3'd1,
    SEC_PAR2  = 3'd2,
    SEC_MAIN1 = 3'd3,
    SEC_MAIN2 = 3'd4
  } sect_e;

endpackage

// File: rtl/secmap_decode.sv
module secmap_decode
  import secmap_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SECT_W-1:0] sect,
  output logic              id_match
);

  localparam int unsigned ARR   = 32'd1 << ADDR_W;
  localparam int unsigned EIGHT = ARR / 8;
  localparam int unsigned SIXT  = ARR / 16;
  localparam int unsigned QUART = ARR / 4;
  localparam int unsigned HALF  = ARR / 2;
  localparam int unsigned BOOT_BASE = TOP_BOOT ? (ARR - EIGHT) : 32'd0;
  localparam int unsigned ID_OFF    = BOOT_BASE + 32'd2;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  generate
    if (TOP_BOOT) begin : g_top
      always_comb begin
        if (a32 >= ARR - EIGHT)             sect = SEC_BOOT;
        else if (a32 >= ARR - EIGHT - SIXT) sect = SEC_PAR1;
        else if (a32 >= ARR - QUART)        sect = SEC_PAR2;
        else if (a32 >= HALF)               sect = SEC_MAIN1;
        else                                sect = SEC_MAIN2;
      end
    end else begin : g_bottom
      always_comb begin
        if (a32 < EIGHT)             sect = SEC_BOOT;
        else if (a32 < EIGHT + SIXT) sect = SEC_PAR1;
        else if (a32 < QUART)        sect = SEC_PAR2;
        else if (a32 < HALF)         sect = SEC_MAIN1;
        else                         sect = SEC_MAIN2;
      end
    end
  endgenerate

  assign id_match = (a32 == ID_OFF);

  always_comb begin
    assert (sect < SECT_W'(NUM_SECT))
      else $error("p_sector_range_r1: sector index out of range");
  end

endmodule

// File: rtl/secmap_lock.sv
module secmap_lock #(
  parameter bit OVR_EN = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic lock_set,
  input  logic hv_override,
  output logic locked,
  output logic eff_lock
);

  logic bypass;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  generate
    if (OVR_EN) begin : g_ovr
      assign bypass = hv_override;
    end else begin : g_no_ovr
      assign bypass = 1'b0;
    end
  endgenerate

  assign eff_lock = locked & ~bypass;

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> locked)
    else $error("p_lock_sticky_r3");

  p_lock_set_r3: assert property (@(posedge clk) disable iff (!por_n)
    lock_set |=> locked)
    else $error("p_lock_set_r3");

endmodule

// File: rtl/secmap_policy.sv
module secmap_policy
  import secmap_pkg::*;
(
  input  op_kind_e            kind,
  input  logic [SECT_W-1:0]   sect,
  input  logic                eff_lock,
  output logic                permit,
  output logic [NUM_SECT-1:0] mask
);

  logic boot_blocked;
  assign boot_blocked = eff_lock && (sect == SEC_BOOT);

  always_comb begin
    unique case (kind)
      OP_PROG, OP_SERASE: permit = ~boot_blocked;
      OP_CERASE:          permit = 1'b1;
      default:            permit = 1'b0;
    endcase
  end

  generate
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_mask
      always_comb begin
        unique case (kind)
          OP_CERASE: mask[i] = (i == 0) ? ~eff_lock : 1'b1;
          OP_SERASE: mask[i] = (sect == SECT_W'(i)) && ~boot_blocked;
          default:   mask[i] = 1'b0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/secmap_lockout.sv
module secmap_lockout
  import secmap_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter bit TOP_BOOT = 1'b0,
  parameter bit OVR_EN   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                op_start,
  input  logic [1:0]          op_kind,
  input  logic                lock_set,
  input  logic                hv_override,
  input  logic                id_mode,
  output logic [SECT_W-1:0]   sector_idx,
  output logic                lock_flag,
  output logic                id_hit,
  output logic                id_bit,
  output logic                dec_valid,
  output logic [1:0]          dec_kind,
  output logic [SECT_W-1:0]   dec_sector,
  output logic                dec_permit,
  output logic [NUM_SECT-1:0] dec_erase_mask
);

  logic                id_match;
  logic                eff_lock;
  logic                nx_permit;
  logic [NUM_SECT-1:0] nx_mask;
  op_kind_e            kind_e;

  assign kind_e = op_kind_e'(op_kind);

  secmap_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_decode (
    .addr     (addr),
    .sect     (sector_idx),
    .id_match (id_match)
  );

  secmap_lock #(.OVR_EN(OVR_EN)) u_lock (
    .clk         (clk),
    .por_n       (por_n),
    .lock_set    (lock_set),
    .hv_override (hv_override),
    .locked      (lock_flag),
    .eff_lock    (eff_lock)
  );

  secmap_policy u_policy (
    .kind     (kind_e),
    .sect     (sector_idx),
    .eff_lock (eff_lock),
    .permit   (nx_permit),
    .mask     (nx_mask)
  );

  assign id_hit = id_mode & id_match;
  assign id_bit = id_hit & lock_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid      <= 1'b0;
      dec_kind       <= 2'd0;
      dec_sector     <= '0;
      dec_permit     <= 1'b0;
      dec_erase_mask <= '0;
    end else begin
      dec_valid <= op_start;
      if (op_start) begin
        dec_kind       <= op_kind;
        dec_sector     <= sector_idx;
        dec_permit     <= nx_permit;
        dec_erase_mask <= nx_mask;
      end
    end
  end

  p_valid_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> dec_valid)
    else $error("p_valid_follows_start_r9");

  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start |=> !dec_valid)
    else $error("p_no_spurious_valid_r9");

  p_boot_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_sector == SEC_BOOT && (dec_kind == 2'd1 || dec_kind == 2'd2)
     && $past(lock_flag) && !(OVR_EN && $past(hv_override))) |-> !dec_permit)
    else $error("p_boot_refused_r4");

  p_chip_keeps_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'd3) |-> (dec_permit && dec_erase_mask[NUM_SECT-1:1] == '1))
    else $error("p_chip_keeps_others_r5");

  p_serase_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'd2) |-> $onehot0(dec_erase_mask))
    else $error("p_serase_onehot_r8");

  p_prog_no_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'd1) |-> dec_erase_mask == '0)
    else $error("p_prog_no_mask_r8");

  p_id_bit_r10: assert property (@(posedge clk) disable iff (!por_n)
    id_bit |-> (id_hit && lock_flag))
    else $error("p_id_bit_r10");

  generate
    if (!OVR_EN) begin : g_chk_no_ovr
      p_override_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 2'd3 && $past(lock_flag)) |-> !dec_erase_mask[0])
        else $error("p_override_ignored_r7");
    end
  endgenerate

endmodule

// File: tb/tb_secmap_lockout.sv
module tb_secmap_lockout;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic [16:0] addr = '0;
  logic        op_start = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic        lock_set = 1'b0;
  logic        hv_override = 1'b0;
  logic        id_mode = 1'b0;

  logic [2:0] b_sec, t_sec, b_dsec, t_dsec;
  logic       b_flag, t_flag, b_idh, t_idh, b_idb, t_idb;
  logic       b_val, t_val, b_perm, t_perm;
  logic [1:0] b_kind, t_kind;
  logic [4:0] b_mask, t_mask;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  secmap_lockout #(.ADDR_W(17), .TOP_BOOT(1'b0), .OVR_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .op_start(op_start),
    .op_kind(op_kind), .lock_set(lock_set), .hv_override(hv_override), .id_mode(id_mode),
    .sector_idx(b_sec), .lock_flag(b_flag), .id_hit(b_idh), .id_bit(b_idb),
    .dec_valid(b_val), .dec_kind(b_kind), .dec_sector(b_dsec), .dec_permit(b_perm),
    .dec_erase_mask(b_mask)
  );

  secmap_lockout #(.ADDR_W(17), .TOP_BOOT(1'b1), .OVR_EN(1'b0)) dut_top (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .op_start(op_start),
    .op_kind(op_kind), .lock_set(lock_set), .hv_override(hv_override), .id_mode(id_mode),
    .sector_idx(t_sec), .lock_flag(t_flag), .id_hit(t_idh), .id_bit(t_idb),
    .dec_valid(t_val), .dec_kind(t_kind), .dec_sector(t_dsec), .dec_permit(t_perm),
    .dec_erase_mask(t_mask)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%05h)", req, act, exp, addr);
    end
  endtask

  function automatic int exp_sec(input int a, input bit top);
    if (!top) begin
      if (a < 'h4000) return 0;
      if (a < 'h6000) return 1;
      if (a < 'h8000) return 2;
      if (a < 'h10000) return 3;
      return 4;
    end
    if (a >= 'h1C000) return 0;
    if (a >= 'h1A000) return 1;
    if (a >= 'h18000) return 2;
    if (a >= 'h10000) return 3;
    return 4;
  endfunction

  function automatic int exp_permit(input int sec, input int k, input bit lk, input bit ovr, input bit oen);
    bit eff = lk && !(ovr && oen);
    if (k == 0) return 0;
    if (k == 3) return 1;
    return (sec == 0 && eff) ? 0 : 1;
  endfunction

  function automatic int exp_mask(input int sec, input int k, input bit lk, input bit ovr, input bit oen);
    bit eff = lk && !(ovr && oen);
    if (k == 3) return eff ? 'b11110 : 'b11111;
    if (k == 2) return (sec == 0 && eff) ? 0 : (1 << sec);
    return 0;
  endfunction

  task automatic do_op(input int a, input int k, input bit ovr, input bit lk);
    int bs, ts;
    @(negedge clk);
    addr = a[16:0]; op_kind = k[1:0]; hv_override = ovr; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0; hv_override = 1'b0;
    bs = exp_sec(a, 1'b0);
    ts = exp_sec(a, 1'b1);
    check("R9 dec_valid", b_val, 1);
    check("R9 dec_kind", b_kind, k);
    check("R1 dec_sector", b_dsec, bs);
    check("R4/R6 permit", b_perm, exp_permit(bs, k, lk, ovr, 1'b1));
    check("R5/R6/R8 mask", b_mask, exp_mask(bs, k, lk, ovr, 1'b1));
    check("R9 top dec_valid", t_val, 1);
    check("R2 top dec_sector", t_dsec, ts);
    check("R4/R7 top permit", t_perm, exp_permit(ts, k, lk, ovr, 1'b0));
    check("R5/R7/R8 top mask", t_mask, exp_mask(ts, k, lk, ovr, 1'b0));
  endtask

  task automatic op_sweep(input bit lk);
    for (int ov = 0; ov < 2; ov++)
      for (int k = 0; k < 4; k++)
        for (int r = 0; r < 16; r++)
          do_op(r * 'h2000 + 'h123, k, ov[0], lk);
    @(negedge clk);
    check("R9 no start no valid", b_val, 0);
    check("R9 top no start no valid", t_val, 0);
  endtask

  task automatic id_checks(input bit lk);
    @(negedge clk);
    id_mode = 1'b1; addr = 17'h00002; #1;
    check("R10 id_hit bottom", b_idh, 1);
    check("R10 id_bit bottom", b_idb, lk);
    check("R10 top off-location", t_idh, 0);
    addr = 17'h1C002; #1;
    check("R10 id_hit top", t_idh, 1);
    check("R10 id_bit top", t_idb, lk);
    check("R10 bottom off-location", b_idb, 0);
    addr = 17'h00003; #1;
    check("R10 id_hit neighbour", b_idh, 0);
    id_mode = 1'b0; addr = 17'h00002; #1;
    check("R10 id_mode low", b_idh, 0);
    check("R10 id_bit mode low", b_idb, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 dec_valid reset", b_val, 0);
    check("R11 dec_permit reset", b_perm, 0);
    check("R11 dec_mask reset", b_mask, 0);
    check("R11 dec_sector reset", t_dsec, 0);
    check("R3 flag after power-on", b_flag, 0);
    por_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2: address sweep with both edges of each 512-byte step
    for (int i = 0; i < 256; i++) begin
      for (int e = 0; e < 2; e++) begin
        int a = i * 'h200 + (e ? 'h1FF : 0);
        addr = a[16:0]; #1;
        check("R1 sector bottom", b_sec, exp_sec(a, 1'b0));
        check("R2 sector top", t_sec, exp_sec(a, 1'b1));
      end
    end

    id_checks(1'b0);
    op_sweep(1'b0);

    // R3: set the flag
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0;
    check("R3 flag set", b_flag, 1);
    check("R3 flag set top", t_flag, 1);

    op_sweep(1'b1);
    id_checks(1'b1);

    // R3: ordinary reset keeps the flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 dec_valid in reset", b_val, 0);
    check("R3 flag through reset", b_flag, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 flag after reset", t_flag, 1);
    do_op('h00100, 1, 1'b0, 1'b1);

    // R3: power-on clear
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    check("R3 flag cleared", b_flag, 0);
    por_n = 1'b1;
    @(negedge clk);
    check("R3 flag stays clear", t_flag, 0);
    do_op('h00100, 2, 1'b0, 1'b0);
    do_op('h1C100, 3, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule